// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block is a single-clock, fully pipelined 64-bit-wide static memory with a built-in four-beat burst sequencer. Every control, address, enable and write-data input is captured in a register on the rising clock edge. A load strobe starts an access at a new base address. A step input then walks a 2-bit beat counter through the other three words of the aligned group of four. The order is set by a mode input: either XOR order (low two address bits XOR beat) or wrapping linear order (low two bits plus beat, modulo 4).

Writes are masked per byte lane, or forced to the full word by a global write input. Two groups of chip selects, one active low and one active high, gate only the start of a new access. A load with any select inactive ends the current burst on that cycle.

Read data leaves through an output register three cycles after its inputs were presented, and further beats follow one per cycle. The array commits writes one cycle late. A forwarding path therefore makes a read issued straight after a write to the same word return the new bytes. The depth is set by `ADDR_W` (16 gives 65536 words; the default is kept small for elaboration).

Top module: `burst_sram`

## Requirements
- R1: Read data for an access whose inputs are present before rising edge n is on `rdata`, with `rdata_vld` high, from edge n+2 until edge n+3. A following beat's data appears one cycle later.
- R2: When `addr_load` is high and every `sel_n` bit is 0 and every `sel` bit is 1, a new access starts at `addr` with the beat counter cleared. This also holds in the middle of a running burst.
- R3: With `order_xor` = 1, beat k of a burst accesses the word whose low two address bits are base[1:0] XOR k.
- R4: With `order_xor` = 0, beat k accesses low bits (base[1:0] + k) mod 4. The address bits above bit 1 always stay those of the base.
- R5: Each cycle with `burst_step` high while a burst is active issues the next beat. After beat 3 the counter wraps, and the fifth word is the first again.
- R6: With `addr_load` and `burst_step` both low, no access is issued and the counter keeps its value. A later step continues from the held beat.
- R7: `addr_load` with any select inactive issues no access and ends the burst. Later steps issue nothing until a selected load.
- R8: A write with `wr_global` = 0 updates exactly the byte lanes whose `wr_lane` bit i is 1 (data bits 8i+7..8i). Other bytes keep their value.
- R9: `wr_global` = 1 writes all eight bytes whatever `wr_lane` holds.
- R10: An access with any effective byte enable is a write and produces no `rdata_vld` pulse.
- R11: A read issued on the cycle right after a write to the same word returns the newly written bytes, merged with the old ones.
- R12: After reset, `rdata_vld` is 0 and no burst is active, so a step alone issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Start an access at `addr` (if selected) |
| burst_step | input | 1 | Advance the beat counter of the active burst |
| order_xor | input | 1 | 1: XOR burst order, 0: linear wrapping order |
| wr_global | input | 1 | Write all byte lanes |
| wr_lane | input | 8 | Per-byte write enables |
| addr | input | ADDR_W | Word address |
| wdata | input | 64 | Write data |
| sel_n | input | N_SEL_LO | Active-low chip selects |
| sel | input | N_SEL_HI | Active-high chip selects |
| rdata | output | 64 | Registered read data |
| rdata_vld | output | 1 | `rdata` holds data of a read issued two cycles before its edge |

## Verification
A beat counter or base register that drifts shows up as the wrong word on `rdata` at the very beat it is used, three cycles after the offending input cycle. Because every written word carries distinct data, a swapped order or a missed wrap is visible at that point. A stale burst-active flag shows as a `rdata_vld` pulse, or a missing one, on the third cycle after a step following a deselect or a hold. A lost pending write or a missed forward shows as old bytes on the read issued right after the write, or on any later read of that word.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int unsigned LANE_W    = 8;
    localparam int unsigned NUM_LANES = 8;
    localparam int unsigned WORD_W    = LANE_W * NUM_LANES;
    localparam int unsigned BURST_W   = 2;

    typedef logic [BURST_W-1:0]   beat_t;
    typedef logic [NUM_LANES-1:0] lane_mask_t;
    typedef logic [WORD_W-1:0]    word_t;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic       start;
        logic       step;
        logic       order_xor;
        logic       wr_global;
        lane_mask_t wr_lane;
    } ctl_t;

    // Low address bits of a beat: XOR order or wrapping add.
    function automatic beat_t beat_offset(beat_t base_lo, beat_t beat, logic use_xor);
        beat_t sum;
        sum = beat_t'(base_lo + beat);
        return use_xor ? (base_lo ^ beat) : sum;
    endfunction

    // Global write overrides the per-lane mask.
    function automatic lane_mask_t eff_mask(logic glob, lane_mask_t lanes);
        return glob ? {NUM_LANES{1'b1}} : lanes;
    endfunction

endpackage

// File: rtl/bsr_capture.sv
module bsr_capture
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W   = 9,
    parameter int unsigned N_SEL_LO = 2,
    parameter int unsigned N_SEL_HI = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                step_i,
    input  logic                order_xor_i,
    input  logic                wr_global_i,
    input  lane_mask_t          wr_lane_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  word_t               data_i,
    input  logic [N_SEL_LO-1:0] sel_n_i,
    input  logic [N_SEL_HI-1:0] sel_i,
    output ctl_t                ctl_o,
    output logic [ADDR_W-1:0]   addr_o,
    output word_t               data_o,
    output logic                selected_o
);

    ctl_t                ctl_q;
    logic [ADDR_W-1:0]   addr_q;
    word_t               data_q;
    logic [N_SEL_LO-1:0] sel_n_q;
    logic [N_SEL_HI-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            sel_n_q <= '1;
            sel_q   <= '0;
        end else begin
            ctl_q.start     <= start_i;
            ctl_q.step      <= step_i;
            ctl_q.order_xor <= order_xor_i;
            ctl_q.wr_global <= wr_global_i;
            ctl_q.wr_lane   <= wr_lane_i;
            addr_q          <= addr_i;
            data_q          <= data_i;
            sel_n_q         <= sel_n_i;
            sel_q           <= sel_i;
        end
    end

    // Every select of either polarity must be asserted.
    assign selected_o = (~|sel_n_q) & (&sel_q);
    assign ctl_o      = ctl_q;
    assign addr_o     = addr_q;
    assign data_o     = data_q;

endmodule

// File: rtl/bsr_seq.sv
module bsr_seq
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              selected_i,
    output acc_kind_e         kind_o,
    output logic [ADDR_W-1:0] acc_addr_o,
    output lane_mask_t        mask_o
);

    logic              active_q, active_d;
    logic [ADDR_W-1:0] base_q, base_d;
    beat_t             beat_q, beat_d;
    logic              issue;
    lane_mask_t        mask_eff;

    always_comb begin
        active_d = active_q;
        base_d   = base_q;
        beat_d   = beat_q;
        issue    = 1'b0;
        if (ctl_i.start) begin
            if (selected_i) begin
                active_d = 1'b1;
                base_d   = addr_i;
                beat_d   = '0;
                issue    = 1'b1;
            end else begin
                active_d = 1'b0;
            end
        end else if (active_q && ctl_i.step) begin
            beat_d = beat_q + beat_t'(1);
            issue  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            beat_q   <= '0;
        end else begin
            active_q <= active_d;
            base_q   <= base_d;
            beat_q   <= beat_d;
        end
    end

    assign mask_eff   = eff_mask(ctl_i.wr_global, ctl_i.wr_lane);
    assign acc_addr_o = {base_d[ADDR_W-1:BURST_W],
                         beat_offset(base_d[BURST_W-1:0], beat_d, ctl_i.order_xor)};
    assign mask_o     = issue ? mask_eff : '0;

    always_comb begin
        if (!issue)         kind_o = ACC_IDLE;
        else if (|mask_eff) kind_o = ACC_WRITE;
        else                kind_o = ACC_READ;
    end

    // R2: a selected load leaves the burst active at beat zero
    assert_load_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.start && selected_i) |=> (active_q && beat_q == '0));

    // R6: no load and no step keeps the counter
    assert_beat_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.start && !ctl_i.step) |=> $stable(beat_q));

    // R7: a deselected load ends the burst
    assert_deselect_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.start && !selected_i) |=> !active_q);

    // R4: a step keeps the upper address bits of the stored base
    assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        (kind_o != ACC_IDLE && !ctl_i.start) |->
            (acc_addr_o[ADDR_W-1:BURST_W] == base_q[ADDR_W-1:BURST_W]));

endmodule

// File: rtl/bsr_array.sv
module bsr_array
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_kind_e         kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  lane_mask_t        mask_i,
    input  word_t             wdata_i,
    output word_t             rdata_o,
    output logic              rvld_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    // Write waiting one cycle before it reaches the array.
    logic              pend_vld;
    logic [ADDR_W-1:0] pend_addr;
    lane_mask_t        pend_mask;
    word_t             pend_data;
    logic              pend_hit;
    logic              rvld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld  <= 1'b0;
            pend_addr <= '0;
            pend_mask <= '0;
            pend_data <= '0;
            rvld_q    <= 1'b0;
        end else begin
            pend_vld  <= (kind_i == ACC_WRITE);
            pend_addr <= addr_i;
            pend_mask <= mask_i;
            pend_data <= wdata_i;
            rvld_q    <= (kind_i == ACC_READ);
        end
    end

    assign pend_hit = pend_vld && (pend_addr == addr_i);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_byte;

        always_ff @(posedge clk) begin
            if (pend_vld && pend_mask[g])
                mem[pend_addr] <= pend_data[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (kind_i == ACC_READ) begin
                if (pend_hit && pend_mask[g])
                    rd_byte <= pend_data[g*LANE_W +: LANE_W];
                else
                    rd_byte <= mem[addr_i];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = rd_byte;
    end

    assign rvld_o = rvld_q;

    // R8: a queued write always carries at least one lane
    assert_pend_lanes_R8: assert property (@(posedge clk) disable iff (rst)
        pend_vld |-> (pend_mask != '0));

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W   = 9,
    parameter int unsigned N_SEL_LO = 2,
    parameter int unsigned N_SEL_HI = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                addr_load,
    input  logic                burst_step,
    input  logic                order_xor,
    input  logic                wr_global,
    input  logic [7:0]          wr_lane,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [63:0]         wdata,
    input  logic [N_SEL_LO-1:0] sel_n,
    input  logic [N_SEL_HI-1:0] sel,
    output logic [63:0]         rdata,
    output logic                rdata_vld
);

    ctl_t              cap_ctl;
    logic [ADDR_W-1:0] cap_addr;
    word_t             cap_data;
    logic              cap_sel;
    acc_kind_e         acc_kind;
    logic [ADDR_W-1:0] acc_addr;
    lane_mask_t        acc_mask;
    word_t             arr_rdata;
    logic              arr_rvld;
    word_t             out_q;
    logic              out_vld_q;

    bsr_capture #(
        .ADDR_W   (ADDR_W),
        .N_SEL_LO (N_SEL_LO),
        .N_SEL_HI (N_SEL_HI)
    ) u_capture (
        .clk         (clk),
        .rst         (rst),
        .start_i     (addr_load),
        .step_i      (burst_step),
        .order_xor_i (order_xor),
        .wr_global_i (wr_global),
        .wr_lane_i   (wr_lane),
        .addr_i      (addr),
        .data_i      (wdata),
        .sel_n_i     (sel_n),
        .sel_i       (sel),
        .ctl_o       (cap_ctl),
        .addr_o      (cap_addr),
        .data_o      (cap_data),
        .selected_o  (cap_sel)
    );

    bsr_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ctl_i      (cap_ctl),
        .addr_i     (cap_addr),
        .selected_i (cap_sel),
        .kind_o     (acc_kind),
        .acc_addr_o (acc_addr),
        .mask_o     (acc_mask)
    );

    bsr_array #(
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .kind_i  (acc_kind),
        .addr_i  (acc_addr),
        .mask_i  (acc_mask),
        .wdata_i (cap_data),
        .rdata_o (arr_rdata),
        .rvld_o  (arr_rvld)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q     <= '0;
            out_vld_q <= 1'b0;
        end else begin
            out_vld_q <= arr_rvld;
            if (arr_rvld)
                out_q <= arr_rdata;
        end
    end

    assign rdata     = out_q;
    assign rdata_vld = out_vld_q;

    // R1: valid output traces back to a read issued two edges earlier
    assert_read_latency_R1: assert property (@(posedge clk) disable iff (rst)
        rdata_vld |-> $past(acc_kind == ACC_READ, 2));

    // R10: a write issued two edges earlier leaves the output quiet
    assert_write_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        $past(acc_kind == ACC_WRITE, 2) |-> !rdata_vld);

endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;

    localparam int AW  = 9;
    localparam int NLO = 2;
    localparam int NHI = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           addr_load = 1'b0;
    logic           burst_step = 1'b0;
    logic           order_xor = 1'b0;
    logic           wr_global = 1'b0;
    logic [7:0]     wr_lane = 8'h00;
    logic [AW-1:0]  addr = '0;
    logic [63:0]    wdata = '0;
    logic [NLO-1:0] sel_n = '0;
    logic [NHI-1:0] sel = '1;
    logic [63:0]    rdata;
    logic           rdata_vld;

    always #4 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .N_SEL_LO(NLO), .N_SEL_HI(NHI)) u_dut (
        .clk(clk), .rst(rst), .addr_load(addr_load), .burst_step(burst_step),
        .order_xor(order_xor), .wr_global(wr_global), .wr_lane(wr_lane),
        .addr(addr), .wdata(wdata), .sel_n(sel_n), .sel(sel),
        .rdata(rdata), .rdata_vld(rdata_vld)
    );

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;

    bit          exp_vld_q [$];
    logic [63:0] exp_dat_q [$];
    string       exp_tag_q [$];
    bit          armed = 1'b0;

    // Reference model state, built from the requirements.
    logic [63:0]    ref_mem [1<<AW];
    bit             m_active = 1'b0;
    logic [AW-1:0]  m_base = '0;
    logic [1:0]     m_beat = '0;
    bit             tb_order = 1'b0;
    logic [NLO-1:0] tb_sel_n = '0;
    logic [NHI-1:0] tb_sel = '1;

    function automatic logic [63:0] pat(int a, int salt);
        return {16'hC0DE, 16'(salt), 16'(a), 16'(a ^ 16'h5A5A)};
    endfunction

    task automatic push(bit v, logic [63:0] d, string t);
        exp_vld_q.push_back(v);
        exp_dat_q.push_back(d);
        exp_tag_q.push_back(t);
    endtask

    // Driver: one input cycle, with the expected result queued.
    task automatic step(string tag, bit ld, bit stp, int a, bit wg, logic [7:0] wl, logic [63:0] d);
        bit            issue;
        bit            sel_ok;
        logic [1:0]    lo;
        logic [AW-1:0] wa;
        logic [7:0]    mask;
        @(posedge clk);
        #2;
        if (!armed) begin
            push(1'b0, '0, "R12");
            push(1'b0, '0, "R12");
            push(1'b0, '0, "R12");
            armed = 1'b1;
        end
        addr_load  = ld;
        burst_step = stp;
        addr       = AW'(a);
        wr_global  = wg;
        wr_lane    = wl;
        wdata      = d;
        order_xor  = tb_order;
        sel_n      = tb_sel_n;
        sel        = tb_sel;
        issue  = 1'b0;
        sel_ok = (tb_sel_n == '0) && (&tb_sel);
        if (ld) begin
            if (sel_ok) begin
                m_active = 1'b1;
                m_base   = AW'(a);
                m_beat   = 2'd0;
                issue    = 1'b1;
            end else begin
                m_active = 1'b0;
            end
        end else if (m_active && stp) begin
            m_beat = m_beat + 2'd1;
            issue  = 1'b1;
        end
        lo   = tb_order ? (m_base[1:0] ^ m_beat) : 2'(m_base[1:0] + m_beat);
        wa   = {m_base[AW-1:2], lo};
        mask = wg ? 8'hFF : wl;
        if (issue && mask != 8'h00) begin
            for (int b = 0; b < 8; b++)
                if (mask[b]) ref_mem[wa][b*8 +: 8] = d[b*8 +: 8];
            push(1'b0, '0, tag);
        end else if (issue) begin
            push(1'b1, ref_mem[wa], tag);
        end else begin
            push(1'b0, '0, tag);
        end
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 8'h00, '0);
    endtask

    // Monitor: pops one expected item per cycle and compares.
    always @(negedge clk) begin
        if (armed && exp_vld_q.size() > 0) begin
            bit          v;
            logic [63:0] d;
            string       t;
            v = exp_vld_q.pop_front();
            d = exp_dat_q.pop_front();
            t = exp_tag_q.pop_front();
            n_run++;
            if (rdata_vld !== v || (v && rdata !== d)) begin
                n_fail++;
                $display("FAIL %s: actual vld=%0b data=%h expected vld=%0b data=%h",
                         t, rdata_vld, rdata, v, d);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual cycles=%0d expected below 20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        n_run++;
        if (rdata_vld !== 1'b0) begin
            n_fail++;
            $display("FAIL R12: actual vld=%0b expected vld=0", rdata_vld);
        end

        // R12: a step with no burst open issues nothing
        step("R12", 0, 1, 0, 0, 8'h00, '0);
        step("R12", 0, 1, 0, 0, 8'h00, '0);

        // R9/R10: global-write linear burst over 0x20..0x23
        tb_order = 1'b0;
        step("R10", 1, 0, 'h20, 1, 8'h00, pat('h20, 1));
        step("R9",  0, 1, 0,    1, 8'h00, pat('h21, 1));
        step("R9",  0, 1, 0,    1, 8'h00, pat('h22, 1));
        step("R10", 0, 1, 0,    1, 8'h00, pat('h23, 1));
        // R8: all-lane masked writes over 0x30..0x33
        step("R8", 1, 0, 'h30, 0, 8'hFF, pat('h30, 2));
        step("R8", 0, 1, 0,    0, 8'hFF, pat('h31, 2));
        step("R8", 0, 1, 0,    0, 8'hFF, pat('h32, 2));
        step("R8", 0, 1, 0,    0, 8'hFF, pat('h33, 2));
        idle("R10");

        // R1/R4/R5: linear read from 0x22, then a fifth beat that wraps
        step("R1", 1, 0, 'h22, 0, 8'h00, '0);
        step("R4", 0, 1, 0, 0, 8'h00, '0);
        step("R4", 0, 1, 0, 0, 8'h00, '0);
        step("R4", 0, 1, 0, 0, 8'h00, '0);
        step("R5", 0, 1, 0, 0, 8'h00, '0);

        // R3: XOR-order read from 0x21
        tb_order = 1'b1;
        step("R3", 1, 0, 'h21, 0, 8'h00, '0);
        step("R3", 0, 1, 0, 0, 8'h00, '0);
        step("R3", 0, 1, 0, 0, 8'h00, '0);
        step("R3", 0, 1, 0, 0, 8'h00, '0);

        // R6: hold in the middle of a burst, then resume
        step("R6", 1, 0, 'h31, 0, 8'h00, '0);
        step("R6", 0, 1, 0, 0, 8'h00, '0);
        step("R6", 0, 0, 0, 0, 8'h00, '0);
        step("R6", 0, 0, 0, 0, 8'h00, '0);
        step("R6", 0, 1, 0, 0, 8'h00, '0);
        step("R6", 0, 1, 0, 0, 8'h00, '0);

        // R7: deselect by an active-low select, then by an active-high one
        tb_sel_n = 2'b01;
        step("R7", 1, 0, 'h20, 0, 8'h00, '0);
        tb_sel_n = '0;
        step("R7", 0, 1, 0, 0, 8'h00, '0);
        step("R7", 0, 1, 0, 0, 8'h00, '0);
        tb_sel = 2'b10;
        step("R7", 1, 0, 'h22, 0, 8'h00, '0);
        tb_sel = '1;
        step("R7", 0, 1, 0, 0, 8'h00, '0);

        // R2: selected load, and a reload in the middle of a burst
        step("R2", 1, 0, 'h20, 0, 8'h00, '0);
        step("R2", 1, 0, 'h30, 0, 8'h00, '0);
        step("R2", 0, 1, 0, 0, 8'h00, '0);
        step("R2", 1, 0, 'h32, 0, 8'h00, '0);
        step("R2", 0, 1, 0, 0, 8'h00, '0);

        // R8/R11: partial write, read right after it
        tb_order = 1'b0;
        step("R8",  1, 0, 'h21, 0, 8'h5A, 64'hFFEE_DDCC_BBAA_9988);
        step("R11", 1, 0, 'h21, 0, 8'h00, '0);

        // R9: global write wins over a one-lane mask, read back later
        step("R9", 1, 0, 'h22, 1, 8'h01, 64'h0123_4567_89AB_CDEF);
        idle("R9");
        idle("R9");
        step("R9", 1, 0, 'h22, 0, 8'h00, '0);

        // R11: full write to 0x33, then immediate read
        step("R11", 1, 0, 'h33, 0, 8'hFF, pat('h33, 7));
        step("R11", 1, 0, 'h33, 0, 8'h00, '0);
        // R8: partial write leaves the other lanes intact
        step("R8", 1, 0, 'h30, 0, 8'h81, 64'hAA00_0000_0000_00BB);
        idle("R8");
        step("R8", 1, 0, 'h30, 0, 8'h00, '0);

        repeat (4) idle("R1");
        while (exp_vld_q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule